// File: doc/BRIEF.md
# Dual-Clock Replay FIFO

This block is a first-in first-out buffer for 36-bit words whose writer and reader run on unrelated clocks. The writer pushes words on `clk_a` and sees two flags computed in its own domain: `in_ready` (room for at least one more word) and the active-low `almost_full_n`. The almost-full threshold is set by the offset input `af_ofs`, called Y below. The reader pops words on `clk_b` and sees `rd_empty`, plus a one-cycle `rd_valid` strobe with each word it pops.

The reader can also replay data. While `rtm` is held high, the read position at which it was first sampled becomes a mark. A pulse on `rewind` moves the read pointer back to that mark, and the words from the mark onward are delivered again. For as long as `rtm` is high, every word from the mark onward counts as occupied, so the writer cannot overwrite data that may still be replayed.

When `rtm` falls, the space already read past the mark is released. The write-side flags then recover after the release passes through a two-stage synchronizer into `clk_a`. The depth is a power-of-two parameter, 512 by default, with 1024 as the other intended setting.

Top module: `replay_fifo`

## Requirements
- R1: While `rst` is high and after it falls, with no traffic, `in_ready` is 1, `almost_full_n` is 1, `rd_empty` is 1 and `rd_valid` is 0.
- R2: Words come out in the order they were accepted. A pop is `rd_en` at a `clk_b` edge while `rd_empty` is 0. After each pop, `rd_valid` is 1 and `rd_data` holds the word after that same edge.
- R3: A write offered while `in_ready` is 0 is dropped and never appears at the read port.
- R4: `in_ready` falls when DEPTH words are held, and not before. Held words are counted from the read pointer, or from the mark while replay mode is active.
- R5: `almost_full_n` is 0 exactly when the held count is at least DEPTH − Y, where Y is `af_ofs`. With DEPTH 512 and Y 8, it is 1 at 503 words and 0 at 504.
- R6: `rd_en` while `rd_empty` is 1 has no effect: `rd_valid` stays 0 and no word is skipped.
- R7: On the first `clk_b` edge that sees `rtm` high, the current read position becomes the mark. A `rewind` pulse while replay mode is active moves the read pointer back to the mark, and the words from the mark are read again in order.
- R8: While replay mode is active, reading past the mark frees no space: with DEPTH words held from the mark, `in_ready` stays 0 and `almost_full_n` stays 0.
- R9: After the first `clk_b` edge that sees `rtm` low, `in_ready` and `almost_full_n` reflect the released space no later than the fourth following `clk_a` rising edge.
- R10: `rewind` while replay mode is inactive is ignored, and reading continues from the current position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset, seen by both clock domains |
| clk_a | input | 1 | Write clock |
| wr_en | input | 1 | Write request |
| wr_data | input | 36 | Word to write |
| af_ofs | input | log2(DEPTH) | Almost-full offset Y |
| in_ready | output | 1 | At least one write location free |
| almost_full_n | output | 1 | Low when DEPTH − Y or more words are held |
| clk_b | input | 1 | Read clock |
| rd_en | input | 1 | Read request |
| rtm | input | 1 | Replay mode, sampled on `clk_b` |
| rewind | input | 1 | Move the read pointer back to the mark while in replay mode |
| rd_data | output | 36 | Word read out |
| rd_valid | output | 1 | `rd_data` holds a freshly popped word |
| rd_empty | output | 1 | No word available to the reader |

## Verification
The main data path is exercised with random, overlapping write and read traffic at independent enable rates on unrelated clock periods. This separates correct ordering across the domain crossing from lost, duplicated or reordered words, and it also produces many reads against an empty buffer.

A directed fill steps the held count across the almost-full threshold one word at a time and then runs it into full. This distinguishes an off-by-one in the threshold or in the full condition, and it confirms that writes refused while full leave no trace at the read port.

A replay pass reads beyond the mark, rewinds, and reads again. It then drops replay mode and also pulses `rewind` with replay mode inactive. Together these separate protected space from released space, a correct mark from a wrong one, and a rewind that is honored from one that leaks through while idle.

// File: rtl/replay_fifo_pkg.sv
package replay_fifo_pkg;
  parameter int unsigned DATA_W = 36;
  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/replay_sync.sv
module replay_sync #(
  parameter int unsigned W      = 10,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/replay_ram.sv
module replay_ram
  import replay_fifo_pkg::*;
#(
  parameter int unsigned AW = 9
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  word_t         wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output word_t         rdata
);
  localparam int unsigned WORDS = 1 << AW;
  word_t mem [WORDS];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/replay_wr_ctl.sv
module replay_wr_ctl #(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned AW    = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] af_ofs,
  input  logic [AW:0]   prot_gray_sync,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [AW:0]   wptr_gray,
  output logic          in_ready,
  output logic          almost_full_n
);
  localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [AW:0] wptr, wptr_n, prot_bin, used;
  logic        push;

  assign prot_bin      = g2b(prot_gray_sync);
  assign used          = wptr - prot_bin;
  assign in_ready      = (used != DEPTH_V);
  assign almost_full_n = (used < (DEPTH_V - {1'b0, af_ofs}));
  assign push          = wr_en && in_ready;
  assign wptr_n        = wptr + (AW+1)'(1);
  assign mem_we        = push;
  assign mem_waddr     = wptr[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr      <= '0;
      wptr_gray <= '0;
    end else if (push) begin
      wptr      <= wptr_n;
      wptr_gray <= wptr_n ^ (wptr_n >> 1);
    end
  end

  // R3: a refused write moves nothing that the read side can see
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !in_ready) |=> $stable(wptr_gray));

  // R4: the held count never exceeds the depth
  a_r4_used_bound: assert property (@(posedge clk) disable iff (rst)
    used <= DEPTH_V);

  // R5: a full buffer always reports almost full as well
  a_r5_af_when_full: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> !almost_full_n);
endmodule

// File: rtl/replay_rd_ctl.sv
module replay_rd_ctl #(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned AW    = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          rtm,
  input  logic          rewind,
  input  logic [AW:0]   wptr_gray_sync,
  output logic          mem_re,
  output logic [AW-1:0] mem_raddr,
  output logic [AW:0]   prot_gray,
  output logic          rd_empty,
  output logic          rd_valid
);
  localparam int unsigned SPAN = DEPTH;

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [AW:0] rptr, rptr_n, mark, mark_n, prot_n, wr_bin;
  logic        rtm_q, rew_go, pop;

  assign wr_bin    = g2b(wptr_gray_sync);
  assign rd_empty  = (rptr == wr_bin);
  assign rew_go    = rewind && rtm_q;
  assign pop       = rd_en && !rd_empty && !rew_go;
  assign mem_re    = pop;
  assign mem_raddr = rptr[AW-1:0];

  always_comb begin
    if (rew_go)   rptr_n = mark;
    else if (pop) rptr_n = rptr + (AW+1)'(1);
    else          rptr_n = rptr;
    mark_n = (rtm && !rtm_q) ? rptr : mark;
    prot_n = rtm ? mark_n : rptr_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr      <= '0;
      mark      <= '0;
      rtm_q     <= 1'b0;
      rd_valid  <= 1'b0;
      prot_gray <= '0;
    end else begin
      rptr      <= rptr_n;
      mark      <= mark_n;
      rtm_q     <= rtm;
      rd_valid  <= pop;
      prot_gray <= prot_n ^ (prot_n >> 1);
    end
  end

  // R6: reading an empty buffer neither moves the pointer nor strobes data
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_empty && !rew_go) |=> ($stable(rptr) && !rd_valid));

  // R7: the mark is frozen while replay mode stays on
  a_r7_mark_hold: assert property (@(posedge clk) disable iff (rst)
    (rtm_q && rtm) |=> $stable(mark));

  // R8: the protected pointer steps by one Gray bit except at release
  a_r8_prot_step: assert property (@(posedge clk) disable iff (rst)
    !$fell(rtm_q) |-> ($countones(prot_gray ^ $past(prot_gray)) <= 1));

  // R10: rewind outside replay mode leaves the read pointer alone
  a_r10_rewind_idle: assert property (@(posedge clk) disable iff (rst)
    (rewind && !rtm_q && !rd_en) |=> $stable(rptr));

  // R2: the distance from the read pointer to the write pointer never exceeds the depth
  a_r2_span: assert property (@(posedge clk) disable iff (rst)
    (wr_bin - rptr) <= (AW+1)'(SPAN));
endmodule

// File: rtl/replay_fifo.sv
module replay_fifo
  import replay_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                     rst,
  input  logic                     clk_a,
  input  logic                     wr_en,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [$clog2(DEPTH)-1:0] af_ofs,
  output logic                     in_ready,
  output logic                     almost_full_n,
  input  logic                     clk_b,
  input  logic                     rd_en,
  input  logic                     rtm,
  input  logic                     rewind,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     rd_valid,
  output logic                     rd_empty
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [AW:0]   wptr_gray, wptr_gray_b, prot_gray, prot_gray_a;
  logic          mem_we, mem_re;
  logic [AW-1:0] mem_waddr, mem_raddr;

  replay_wr_ctl #(.DEPTH(DEPTH), .AW(AW)) u_wr (
    .clk(clk_a), .rst(rst), .wr_en(wr_en), .af_ofs(af_ofs),
    .prot_gray_sync(prot_gray_a), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .wptr_gray(wptr_gray), .in_ready(in_ready), .almost_full_n(almost_full_n)
  );

  replay_rd_ctl #(.DEPTH(DEPTH), .AW(AW)) u_rd (
    .clk(clk_b), .rst(rst), .rd_en(rd_en), .rtm(rtm), .rewind(rewind),
    .wptr_gray_sync(wptr_gray_b), .mem_re(mem_re), .mem_raddr(mem_raddr),
    .prot_gray(prot_gray), .rd_empty(rd_empty), .rd_valid(rd_valid)
  );

  replay_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_sync_a (
    .clk(clk_a), .rst(rst), .d(prot_gray), .q(prot_gray_a)
  );

  replay_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_sync_b (
    .clk(clk_b), .rst(rst), .d(wptr_gray), .q(wptr_gray_b)
  );

  replay_ram #(.AW(AW)) u_ram (
    .wclk(clk_a), .we(mem_we), .waddr(mem_waddr), .wdata(wr_data),
    .rclk(clk_b), .re(mem_re), .raddr(mem_raddr), .rdata(rd_data)
  );
endmodule

// File: tb/tb_replay_fifo.sv
`timescale 1ns/1ps
module tb_replay_fifo;
  localparam int DEPTH = 512;
  localparam int Y     = 8;

  logic        rst, clk_a, clk_b;
  logic        wr_en, rd_en, rtm, rewind;
  logic [35:0] wr_data, rd_data;
  logic [8:0]  af_ofs;
  logic        in_ready, almost_full_n, rd_valid, rd_empty;

  int checks = 0, errors = 0;
  int wcnt = 0, ridx = 0, mark_idx = 0;
  bit done = 0;

  replay_fifo #(.DEPTH(DEPTH)) dut (
    .rst(rst), .clk_a(clk_a), .wr_en(wr_en), .wr_data(wr_data), .af_ofs(af_ofs),
    .in_ready(in_ready), .almost_full_n(almost_full_n), .clk_b(clk_b),
    .rd_en(rd_en), .rtm(rtm), .rewind(rewind), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_empty(rd_empty)
  );

  initial clk_a = 0;
  always #2.5 clk_a = ~clk_a;
  initial clk_b = 0;
  always #3.55 clk_b = ~clk_b;

  function automatic logic [35:0] make_word(input int n);
    return {4'hC, n[15:0], ~n[15:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1; wr_en = 0; rd_en = 0; rtm = 0; rewind = 0; wr_data = '0; af_ofs = 9'(Y);
    repeat (6) @(posedge clk_b);
    @(negedge clk_a);
    chk(in_ready === 1'b1 && almost_full_n === 1'b1, "R1", {34'd0, in_ready, almost_full_n}, 36'd3);
    @(negedge clk_b);
    rst = 0;
    wcnt = 0; ridx = 0;
    repeat (4) @(negedge clk_b);
    chk(rd_empty === 1'b1 && rd_valid === 1'b0, "R1", {34'd0, rd_empty, rd_valid}, 36'd2);
    @(negedge clk_a);
    chk(in_ready === 1'b1 && almost_full_n === 1'b1, "R1", {34'd0, in_ready, almost_full_n}, 36'd3);
  endtask

  task automatic write_burst(input int n, input int pct);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_a);
      wr_en   = (($urandom % 100) < pct);
      wr_data = make_word(wcnt);
      if (wr_en && in_ready) wcnt++;
    end
    @(negedge clk_a);
    wr_en = 0;
  endtask

  task automatic write_upto(input int target);
    while (wcnt < target) begin
      @(negedge clk_a);
      wr_en   = 1;
      wr_data = make_word(wcnt);
      if (in_ready) wcnt++;
    end
    @(negedge clk_a);
    wr_en = 0;
  endtask

  task automatic read_burst(input int n, input int pct, input string tag);
    bit pend = 0, pend_e = 0;
    for (int i = 0; i <= n; i++) begin
      @(negedge clk_b);
      if (pend) begin
        chk(rd_valid === 1'b1 && rd_data === make_word(ridx), tag, rd_data, make_word(ridx));
        ridx++;
      end else if (pend_e) begin
        chk(rd_valid === 1'b0, "R6", {35'd0, rd_valid}, 36'd0);
      end
      if (i < n) begin
        rd_en  = (($urandom % 100) < pct);
        pend   = rd_en && !rd_empty;
        pend_e = rd_en && rd_empty;
      end else begin
        rd_en = 0; pend = 0; pend_e = 0;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    do_reset();

    // R6: reads right after reset find nothing
    read_burst(6, 100, "R6");
    chk(ridx == 0, "R6", 36'(ridx), 36'd0);

    // R2: random overlapping traffic
    fork
      write_burst(700, 60);
      read_burst(1000, 45, "R2");
    join
    repeat (10) @(negedge clk_b);
    read_burst(DEPTH + 20, 100, "R2");
    chk(rd_empty === 1'b1 && ridx == wcnt, "R2", 36'(ridx), 36'(wcnt));

    // R5 / R4 / R3: directed fill
    do_reset();
    write_upto(DEPTH - Y - 1);
    chk(almost_full_n === 1'b1, "R5", {35'd0, almost_full_n}, 36'd1);
    write_upto(DEPTH - Y);
    chk(almost_full_n === 1'b0 && in_ready === 1'b1, "R5", {34'd0, almost_full_n, in_ready}, 36'd1);
    write_upto(DEPTH - 1);
    chk(in_ready === 1'b1, "R4", {35'd0, in_ready}, 36'd1);
    write_upto(DEPTH);
    chk(in_ready === 1'b0, "R4", {35'd0, in_ready}, 36'd0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_a);
      wr_en = 1; wr_data = 36'hF0BAD0BAD;
      chk(in_ready === 1'b0, "R3", {35'd0, in_ready}, 36'd0);
    end
    @(negedge clk_a);
    wr_en = 0;

    // R7 / R8: replay mode
    repeat (6) @(negedge clk_b);
    rtm = 1;
    @(negedge clk_b);
    mark_idx = ridx;
    read_burst(20, 100, "R7");
    repeat (8) @(negedge clk_a);
    chk(in_ready === 1'b0 && almost_full_n === 1'b0, "R8", {34'd0, in_ready, almost_full_n}, 36'd0);
    @(negedge clk_b);
    rewind = 1;
    @(negedge clk_b);
    rewind = 0;
    ridx = mark_idx;
    read_burst(25, 100, "R7");

    // R9: release
    @(negedge clk_b);
    rtm = 0;
    @(posedge clk_b);
    repeat (4) @(posedge clk_a);
    @(negedge clk_a);
    chk(in_ready === 1'b1 && almost_full_n === 1'b1, "R9", {34'd0, in_ready, almost_full_n}, 36'd3);

    // R10: rewind with replay mode off
    @(negedge clk_b);
    rewind = 1;
    @(negedge clk_b);
    rewind = 0;
    read_burst(5, 100, "R10");
    chk(ridx == 30, "R10", 36'(ridx), 36'd30);

    // R3: drain, refused words must not show up
    read_burst(DEPTH, 100, "R3");
    chk(rd_empty === 1'b1 && ridx == DEPTH, "R3", 36'(ridx), 36'(DEPTH));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_a);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule